// File: doc/BRIEF.md
# Tear-Free Byte Bridge for a 16-bit Counter

This bridge lets a bus that is only one byte wide read and load a 16-bit counter without mixing bytes from two different counter values. For writes, the high byte goes first into a write shadow register and the counter does not change. The following low-byte write then loads the counter with the shadow contents and the new low byte, in one cycle, through a load port.

For reads, a low-byte read returns the live low byte. In the same cycle it copies the live high byte into a separate read shadow register. A later high-byte read returns that copy, so the two bytes always come from one counter value.

The counter itself is not part of this block. The block only sees the live count and drives the load strobe and load value. If the high shadow is left at FFh for counting up, or 00h for counting down, every later low-byte write reloads only the low byte. This makes the counter behave as an 8-bit counter.

Top module: `cnt_byte_bridge`

## Requirements
- R1: After reset, both the write shadow and the read shadow hold 00h. A high-byte read then returns 00h, and a low-byte write loads {00h, data}.
- R2: A high-byte write with no low-byte write in the same cycle keeps `ld_en` low. It stores `wdata` into the write shadow, starting from the next cycle.
- R3: A low-byte write raises `ld_en` in that same cycle, with `ld_val` = {write shadow, `wdata`}. Bits 15:8 come from the shadow and bits 7:0 from `wdata`.
- R4: Back-to-back low-byte writes with no high-byte write between them reuse the same shadow high byte. A shadow of FFh or 00h therefore persists and gives 8-bit reload behaviour.
- R5: During a low-byte read, `rdata` equals the live `cnt_val[7:0]` in that cycle. `cnt_val[15:8]` of that cycle is captured into the read shadow.
- R6: A high-byte read with no low-byte read in the same cycle returns the read shadow, not the live `cnt_val[15:8]`.
- R7: Each low-byte read recaptures the live high byte, even when no high-byte read has happened since the previous low-byte read.
- R8: High-byte writes never change the read shadow, and reads never change the write shadow.
- R9: With neither read strobe high, `rdata` is 00h.
- R10: When both read strobes are high together, `rdata` returns the live low byte and the read shadow is recaptured.
- R11: When both write strobes are high together, the load uses the write shadow as it was before that cycle. The shadow takes the new `wdata` for later loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wdata | input | 8 | Bus write data |
| wr_hi | input | 1 | High-byte write strobe |
| wr_lo | input | 1 | Low-byte write strobe |
| rd_hi | input | 1 | High-byte read strobe |
| rd_lo | input | 1 | Low-byte read strobe |
| rdata | output | 8 | Bus read data (combinational) |
| cnt_val | input | 16 | Live counter value |
| ld_en | output | 1 | Counter load strobe |
| ld_val | output | 16 | Counter load value |

## Verification
The case that matters is a low-byte read landing in the same cycle as a low-byte write that reloads a running counter. The bench models the counter, giving the load priority over the increment. It sets a new high shadow, lets the counter run, then asserts both low-byte strobes at once. The check is that `rdata` carries the pre-load live low byte, that the load value is the new word, and that the next high-byte read returns the pre-load high byte. Simultaneous high and low strobes on each side are also provoked and judged against R10 and R11.

// File: rtl/cnt_byte_bridge.sv
module cnt_byte_bridge #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BW-1:0]   wdata,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic            rd_hi,
  input  logic            rd_lo,
  output logic [BW-1:0]   rdata,
  input  logic [2*BW-1:0] cnt_val,
  output logic            ld_en,
  output logic [2*BW-1:0] ld_val
);
  localparam int CW = 2 * BW;

  logic [BW-1:0] wr_shadow;
  logic [BW-1:0] rd_shadow;

  always_ff @(posedge clk) begin
    if (!rst_n)     wr_shadow <= '0;
    else if (wr_hi) wr_shadow <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_shadow <= '0;
    else if (rd_lo) rd_shadow <= cnt_val[CW-1:BW];
  end

  assign ld_en  = wr_lo;
  assign ld_val = {wr_shadow, wdata};
  assign rdata  = rd_lo ? cnt_val[BW-1:0] :
                  rd_hi ? rd_shadow       : '0;
endmodule

// File: rtl/cnt_byte_bridge_chk.sv
module cnt_byte_bridge_chk #(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [BW-1:0]   wdata,
  input logic            wr_hi,
  input logic            wr_lo,
  input logic            rd_hi,
  input logic            rd_lo,
  input logic [BW-1:0]   rdata,
  input logic [2*BW-1:0] cnt_val,
  input logic            ld_en,
  input logic [2*BW-1:0] ld_val
);
  localparam int CW = 2 * BW;

  p_hi_write_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |-> !ld_en);

  p_shadow_applied_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_hi) && wr_lo) |-> (ld_val[CW-1:BW] == $past(wdata)));

  p_repeat_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_lo) && !$past(wr_hi) && wr_lo)
      |-> (ld_val[CW-1:BW] == $past(ld_val[CW-1:BW])));

  p_hi_read_snapshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rd_lo) && rd_hi && !rd_lo)
      |-> (rdata == $past(cnt_val[CW-1:BW])));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !rd_hi) |-> (rdata == '0));
endmodule

bind cnt_byte_bridge cnt_byte_bridge_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdata(wdata), .wr_hi(wr_hi), .wr_lo(wr_lo),
  .rd_hi(rd_hi), .rd_lo(rd_lo), .rdata(rdata), .cnt_val(cnt_val),
  .ld_en(ld_en), .ld_val(ld_val)
);

// File: tb/tb_cnt_byte_bridge.sv
module tb_cnt_byte_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  wdata = '0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0, rd_hi = 1'b0, rd_lo = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] cnt;
  logic        ld_en;
  logic [15:0] ld_val;
  logic        cnt_en = 1'b0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cnt_byte_bridge dut (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .rdata(rdata), .cnt_val(cnt),
    .ld_en(ld_en), .ld_val(ld_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (ld_en) cnt <= ld_val;
    else if (cnt_en) cnt <= cnt + 16'd1;
  end

  // {wh,wl,rh,rl}, wdata, exp_ld, exp_ld_val, exp_rdata, requirement
  localparam logic [40:0] VEC [19] = '{
    {4'b0100, 8'h34, 1'b1, 16'h0034, 8'h00, 4'd1},  // R1 shadow 00 after reset
    {4'b1000, 8'h12, 1'b0, 16'h0000, 8'h00, 4'd2},  // R2 high write, no load
    {4'b0100, 8'h56, 1'b1, 16'h1256, 8'h00, 4'd3},  // R3
    {4'b0100, 8'h78, 1'b1, 16'h1278, 8'h00, 4'd4},  // R4 repeat low write
    {4'b0001, 8'h00, 1'b0, 16'h0000, 8'h78, 4'd5},  // R5 low read, snapshot 12
    {4'b1000, 8'hAB, 1'b0, 16'h0000, 8'h00, 4'd2},  // R2
    {4'b0100, 8'hCD, 1'b1, 16'hABCD, 8'h00, 4'd3},  // R3
    {4'b0010, 8'h00, 1'b0, 16'h0000, 8'h12, 4'd6},  // R6 shadow, not live AB
    {4'b0001, 8'h00, 1'b0, 16'h0000, 8'hCD, 4'd7},  // R7 recapture AB
    {4'b1000, 8'hFF, 1'b0, 16'h0000, 8'h00, 4'd8},  // R8 write leaves read shadow
    {4'b0010, 8'h00, 1'b0, 16'h0000, 8'hAB, 4'd8},  // R8
    {4'b0100, 8'h10, 1'b1, 16'hFF10, 8'h00, 4'd4},  // R4 8-bit mode
    {4'b0100, 8'h20, 1'b1, 16'hFF20, 8'h00, 4'd4},  // R4 FF persists
    {4'b0011, 8'h00, 1'b0, 16'h0000, 8'h20, 4'd10}, // R10 both reads
    {4'b0010, 8'h00, 1'b0, 16'h0000, 8'hFF, 4'd10}, // R10 recaptured
    {4'b1100, 8'h00, 1'b1, 16'hFF00, 8'h00, 4'd11}, // R11 old shadow used
    {4'b0100, 8'h05, 1'b1, 16'h0005, 8'h00, 4'd11}, // R11 new shadow later
    {4'b0001, 8'h00, 1'b0, 16'h0000, 8'h05, 4'd5},  // R5
    {4'b0000, 8'h00, 1'b0, 16'h0000, 8'h00, 4'd9}   // R9 idle read data
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [7:0] d);
    @(negedge clk);
    {wr_hi, wr_lo, rd_hi, rd_lo} = c;
    wdata = d;
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    logic [7:0] hi_a;
    repeat (3) @(posedge clk);
    drive(4'b0010, 8'h00);
    chk(rdata == 8'h00, "R1 read shadow reset", rdata, 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      drive(VEC[i][40:37], VEC[i][36:29]);
      chk(ld_en == VEC[i][28], $sformatf("R%0d vec%0d ld_en", VEC[i][3:0], i), ld_en, VEC[i][28]);
      if (VEC[i][28])
        chk(ld_val == VEC[i][27:12], $sformatf("R%0d vec%0d ld_val", VEC[i][3:0], i),
            ld_val, VEC[i][27:12]);
      chk(rdata == VEC[i][11:4], $sformatf("R%0d vec%0d rdata", VEC[i][3:0], i),
          rdata, VEC[i][11:4]);
    end

    // R7: running counter crossing into a new high byte
    drive(4'b1000, 8'h00);
    drive(4'b0100, 8'hFE);
    @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b1;
    drive(4'b0001, 8'h00);
    chk(rdata == cnt[7:0], "R5 live low byte", rdata, cnt[7:0]);
    drive(4'b0001, 8'h00);
    chk(rdata == cnt[7:0], "R7 live low byte again", rdata, cnt[7:0]);
    hi_a = cnt[15:8];
    drive(4'b0000, 8'h00);
    drive(4'b0010, 8'h00);
    chk(rdata == hi_a, "R7 recaptured high byte", rdata, hi_a);

    // R5/R8: low read coincides with a low write on a running counter
    drive(4'b1000, 8'h7A);
    drive(4'b0101, 8'h33);
    hi_a = cnt[15:8];
    chk(rdata == cnt[7:0], "R5 pre-load low byte", rdata, cnt[7:0]);
    chk(ld_en && ld_val == 16'h7A33, "R3 load during read", ld_val, 16'h7A33);
    drive(4'b0010, 8'h00);
    chk(rdata == hi_a, "R8 pre-load high byte held", rdata, hi_a);
    chk(cnt[15:8] == 8'h7A, "R3 counter took load", cnt[15:8], 8'h7A);
    cnt_en = 1'b0;

    // R1: reset in mid-run clears both shadows
    drive(4'b0000, 8'h00);
    rst_n = 1'b0;
    drive(4'b0000, 8'h00);
    drive(4'b0000, 8'h00);
    rst_n = 1'b1;
    drive(4'b0010, 8'h00);
    chk(rdata == 8'h00, "R1 read shadow after reset", rdata, 0);
    drive(4'b0100, 8'h44);
    chk(ld_val == 16'h0044, "R1 write shadow after reset", ld_val, 16'h0044);
    drive(4'b0000, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule